// File: doc/BRIEF.md
# Framed Readout Record Serializer

This block turns a stream of typed readout records into a byte stream for a downstream 8b10b encoder. Each record enters on a ready/valid port as a kind code, a field bundle and an end-of-frame flag. The block packs the fields into a 24-bit word with the layout for that kind, then emits the word as three bytes. A frame opens with a start comma, carries one or more records and closes with an end comma after the record flagged as last. When no frame is open, the link carries idle commas.

The output side always presents a symbol: a byte plus a flag that marks it as a control character. The encoder consumes the symbol on any clock edge where it holds `out_ready` high. While `out_ready` is low, the symbol holds and nothing is lost. Inside a frame, a record that is late is covered by idle commas placed between whole records. The FSM has five states:

- `ST_IDLE`: between frames. It sends the idle comma and moves to `ST_SOF` when it accepts a record.
- `ST_SOF`: sends the start comma, then moves to `ST_REC`.
- `ST_REC`: sends the held record byte by byte. After the third byte it goes to one of three states:
  - `ST_EOF` if the record was flagged last.
  - `ST_REC` again if the next record is offered.
  - `ST_GAP` otherwise.
- `ST_GAP`: an open frame waiting for its next record. It sends idle commas and returns to `ST_REC` when it accepts a record.
- `ST_EOF`: sends the end comma, then always returns to `ST_IDLE`.

Top module: `rec_frame_serializer`

## Requirements
- R1: During reset and right after it, the output symbol is the idle comma, byte 0x3C with `out_k`=1, and `in_ready` is 0 while `out_ready` is 0.
- R2: While no frame is open and no record is offered, every symbol is the idle comma 0x3C with `out_k`=1.
- R3: A record accepted with no frame open is preceded by the start comma 0xFC with `out_k`=1. The symbol right after the start comma is a record byte.
- R4: Each record goes out as three bytes with `out_k`=0, bits 23:16 first, then 15:8, then 7:0. `out_k` is 1 only on the bytes 0x3C, 0xFC and 0xBC.
- R5: Kind 0 (data record) uses all of `in_fields` as the word: bits 23:17 column, bits 16:8 row, bits 7:4 ToT of the top pixel, bits 3:0 ToT of the bottom pixel. With a column from 1 to 80 the first byte is at most 0xA1, so it never equals a type code below.
- R6: Kind 1 (data header) gives the word {0xE9, 4'b0000, in_fields[11:8] trigger id, in_fields[7:0] crossing id}.
- R7: Kind 2 (address record) gives the word {0xEA, in_fields[15] target select (0 global register, 1 shift register), in_fields[14:0] address}.
- R8: Kind 3 (value record) gives {0xEC, in_fields[15:0]}. A value record may open a frame on its own. Kind 4 and any other code (service record) give {0xEF, in_fields[15:0]}.
- R9: After the third byte of a record accepted with `in_last`=1, the next symbol is the end comma 0xBC with `out_k`=1. The symbol after it is always one idle comma, before any next start comma.
- R10: When a record that is not last finishes and the next one is not yet offered, idle commas (0x3C, K) fill the frame, and only between whole records. The frame then resumes with no second start comma.
- R11: A symbol advances only on an edge where `out_ready` is 1, and holds unchanged while `out_ready` is 0. `in_ready` is never 1 while `out_ready` is 0, so no record or byte is dropped under back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A record is offered |
| in_ready | output | 1 | The offered record is taken on this edge |
| in_kind | input | 3 | Record kind: 0 data, 1 header, 2 address, 3 value, 4 service |
| in_fields | input | 24 | Field bundle for the record kind |
| in_last | input | 1 | This record closes the frame |
| out_ready | input | 1 | The encoder consumes the current symbol on this edge |
| out_byte | output | 8 | Current symbol byte |
| out_k | output | 1 | Current symbol is a control character |

## Verification
The symbol and `in_ready` are combinational from the state, the held record and `out_ready`. A record is therefore taken on the same edge as the handshake. Its start comma or first byte is presented from the next cycle, and each later symbol appears one cycle after an edge where it was consumed. The bench drives all inputs at the falling edge. It samples a quarter period later and treats a sampled symbol as consumed only when `out_ready` was high in that sample. Its decoder then rebuilds frames and words from exactly the consumed symbols and compares them with the words queued by the driver.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    localparam int REC_W   = 24;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = REC_W / BYTE_W;
    localparam int IDX_W   = $clog2(NBYTES);
    localparam int KIND_W  = 3;
    localparam int CODE_W  = REC_W - 16;

    localparam logic [BYTE_W-1:0] K_IDLE = 8'h3C;
    localparam logic [BYTE_W-1:0] K_SOF  = 8'hFC;
    localparam logic [BYTE_W-1:0] K_EOF  = 8'hBC;

    localparam logic [CODE_W-1:0] CODE_HDR = 8'hE9;
    localparam logic [CODE_W-1:0] CODE_ADR = 8'hEA;
    localparam logic [CODE_W-1:0] CODE_VAL = 8'hEC;
    localparam logic [CODE_W-1:0] CODE_SVC = 8'hEF;

    typedef enum logic [KIND_W-1:0] {
        KIND_DATA = 3'd0,
        KIND_HDR  = 3'd1,
        KIND_ADR  = 3'd2,
        KIND_VAL  = 3'd3,
        KIND_SVC  = 3'd4
    } rec_kind_e;

    typedef enum logic [1:0] {
        SYM_IDLE,
        SYM_SOF,
        SYM_EOF,
        SYM_DATA
    } sym_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF,
        ST_REC,
        ST_GAP,
        ST_EOF
    } fsm_e;
endpackage

// File: rtl/rfs_formatter.sv
module rfs_formatter
    import rfs_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic [REC_W-1:0]  fields,
    output logic [REC_W-1:0]  word
);
    always_comb begin
        case (kind)
            KIND_DATA: word = fields;
            KIND_HDR:  word = {CODE_HDR, 4'b0000, fields[11:0]};
            KIND_ADR:  word = {CODE_ADR, fields[15:0]};
            KIND_VAL:  word = {CODE_VAL, fields[15:0]};
            default:   word = {CODE_SVC, fields[15:0]};
        endcase
    end
endmodule

// File: rtl/rfs_lane_select.sv
module rfs_lane_select
    import rfs_pkg::*;
(
    input  logic [REC_W-1:0]  word,
    input  logic [IDX_W-1:0]  idx,
    input  sym_e              sym,
    output logic [BYTE_W-1:0] sym_byte,
    output logic              sym_k
);
    logic [BYTE_W-1:0] lanes [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lanes[g] = word[REC_W-1-g*BYTE_W -: BYTE_W];
    end

    always_comb begin
        unique case (sym)
            SYM_IDLE: begin sym_byte = K_IDLE;     sym_k = 1'b1; end
            SYM_SOF:  begin sym_byte = K_SOF;      sym_k = 1'b1; end
            SYM_EOF:  begin sym_byte = K_EOF;      sym_k = 1'b1; end
            SYM_DATA: begin sym_byte = lanes[idx]; sym_k = 1'b0; end
        endcase
    end
endmodule

// File: rtl/rec_frame_serializer.sv
module rec_frame_serializer
    import rfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_kind,
    input  logic [23:0]       in_fields,
    input  logic              in_last,
    input  logic              out_ready,
    output logic [7:0]        out_byte,
    output logic              out_k
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    fsm_e              state_q, state_d;
    logic [REC_W-1:0]  word_q, fmt_word;
    logic              last_q;
    logic [IDX_W-1:0]  idx_q;
    logic              take;
    logic              step;
    sym_e              sym;

    rfs_formatter u_fmt (
        .kind   (in_kind),
        .fields (in_fields),
        .word   (fmt_word)
    );

    rfs_lane_select u_lane (
        .word     (word_q),
        .idx      (idx_q),
        .sym      (sym),
        .sym_byte (out_byte),
        .sym_k    (out_k)
    );

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        step    = 1'b0;
        sym     = SYM_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                sym = SYM_IDLE;
                if (out_ready && in_valid) begin
                    take    = 1'b1;
                    state_d = ST_SOF;
                end
            end
            ST_SOF: begin
                sym = SYM_SOF;
                if (out_ready) state_d = ST_REC;
            end
            ST_REC: begin
                sym = SYM_DATA;
                if (out_ready) begin
                    if (idx_q != LAST_IDX) begin
                        step = 1'b1;
                    end else if (last_q) begin
                        state_d = ST_EOF;
                    end else if (in_valid) begin
                        take = 1'b1;
                    end else begin
                        state_d = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                sym = SYM_IDLE;
                if (out_ready && in_valid) begin
                    take    = 1'b1;
                    state_d = ST_REC;
                end
            end
            ST_EOF: begin
                sym = SYM_EOF;
                if (out_ready) state_d = ST_IDLE;
            end
        endcase
        in_ready = take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            last_q  <= 1'b0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                word_q <= fmt_word;
                last_q <= in_last;
                idx_q  <= '0;
            end else if (step) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       out_ready,
    input logic [7:0] out_byte,
    input logic       out_k
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |=> $stable(out_byte) && $stable(out_k)); // R11

    AST_TAKE_NEEDS_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> out_ready); // R11

    AST_K_ONLY_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
        out_k |-> (out_byte == 8'h3C || out_byte == 8'hFC || out_byte == 8'hBC)); // R4

    AST_SOF_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && out_k && out_byte == 8'hFC) |=> !out_k); // R3

    AST_EOF_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && out_k && out_byte == 8'hBC) |=> (out_k && out_byte == 8'h3C)); // R9
endmodule

bind rec_frame_serializer rfs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_k     (out_k)
);

// File: tb/rec_frame_serializer_bench.sv
module rec_frame_serializer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_kind = '0;
    logic [23:0] in_fields = '0;
    logic        in_last = 1'b0;
    logic        out_ready = 1'b0;
    logic [7:0]  out_byte;
    logic        out_k;

    int n_checks = 0;
    int n_fail = 0;
    int ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    int cyc = 0;

    logic [23:0] exp_word [$];
    logic        exp_last [$];
    string       exp_tag  [$];

    logic        in_frame = 1'b0;
    int          nbytes = 0;
    logic [23:0] acc = '0;
    logic        prev_last = 1'b0;
    logic        prev_eof = 1'b0;
    logic        prev_sof = 1'b0;
    logic        prev_stall = 1'b0;
    logic [7:0]  prev_byte = '0;
    logic        prev_kf = 1'b0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rec_frame_serializer u_rec_frame_serializer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_fields(in_fields), .in_last(in_last),
        .out_ready(out_ready), .out_byte(out_byte), .out_k(out_k)
    );

    task automatic check(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [23:0] model(input logic [2:0] k, input logic [23:0] f);
        case (k)
            3'd0: return f;
            3'd1: return {8'hE9, 4'h0, f[11:8], f[7:0]};
            3'd2: return {8'hEA, f[15], f[14:0]};
            3'd3: return {8'hEC, f[15:0]};
            default: return {8'hEF, f[15:0]};
        endcase
    endfunction

    always @(negedge clk) begin
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!rst_n) out_ready = 1'b0;
        else case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = (cyc % 3) != 0;
            default: out_ready = lfsr[0] | lfsr[3];
        endcase
    end

    task automatic send(input logic [2:0] k, input logic [23:0] f, input logic last, input string tag);
        exp_word.push_back(model(k, f));
        exp_last.push_back(last);
        exp_tag.push_back(tag);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_fields = f; in_last = last;
        forever begin
            #(CLK_PERIOD/4);
            if (in_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: decode consumed symbols
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n) begin
            if (prev_stall)
                check(out_byte == prev_byte && out_k == prev_kf, "R11 symbol held under stall",
                      {23'd0, out_k, out_byte}, {23'd0, prev_kf, prev_byte});
            if (!out_ready && in_ready)
                check(1'b0, "R11 in_ready while out_ready low", 32'(in_ready), 32'd0);
            prev_stall = !out_ready;
            prev_byte  = out_byte;
            prev_kf    = out_k;
            if (out_ready) begin
                if (prev_eof)
                    check(out_k && out_byte == 8'h3C, "R9 idle after end comma", {23'd0, out_k, out_byte}, 32'h13C);
                if (prev_sof)
                    check(!out_k, "R3 record byte after start comma", 32'(out_k), 32'd0);
                prev_eof = 1'b0;
                prev_sof = 1'b0;
                if (out_k) begin
                    if (out_byte == 8'h3C) begin
                        if (in_frame)
                            check(nbytes == 0, "R10 fill only between records", nbytes, 0);
                    end else if (out_byte == 8'hFC) begin
                        check(!in_frame, "R3 start comma outside frame", 32'(in_frame), 32'd0);
                        in_frame = 1'b1; nbytes = 0; prev_sof = 1'b1;
                    end else if (out_byte == 8'hBC) begin
                        check(in_frame && nbytes == 0 && prev_last, "R9 end comma after last record",
                              {in_frame, prev_last}, 32'd3);
                        in_frame = 1'b0; prev_eof = 1'b1;
                    end else begin
                        check(1'b0, "R4 unknown control byte", out_byte, 32'h3C);
                    end
                end else begin
                    if (!in_frame) check(1'b0, "R4 data byte outside frame", out_byte, 32'h3C);
                    acc = {acc[15:0], out_byte};
                    nbytes++;
                    if (nbytes == 3) begin
                        nbytes = 0;
                        if (exp_word.size() == 0) begin
                            check(1'b0, "R4 unexpected record", acc, 0);
                        end else begin
                            automatic logic [23:0] w = exp_word.pop_front();
                            automatic string t = exp_tag.pop_front();
                            prev_last = exp_last.pop_front();
                            check(acc == w, t, acc, w);
                        end
                    end
                end
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

    task automatic wait_drain();
        while (exp_word.size() != 0 || in_frame) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #(CLK_PERIOD/4);
        check(out_k && out_byte == 8'h3C, "R1 reset symbol", {23'd0, out_k, out_byte}, 32'h13C);
        check(!in_ready, "R1 in_ready low in reset", 32'(in_ready), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk); #(CLK_PERIOD/4);
            check(out_k && out_byte == 8'h3C, "R2 idle with no frame", {23'd0, out_k, out_byte}, 32'h13C);
        end

        // frame A: header + two data records (R5 R6), full rate
        ready_mode = 0;
        send(3'd1, 24'h000_5A7, 1'b0, "R6 header word");
        send(3'd0, {7'd1, 9'd300, 4'd9, 4'd3}, 1'b0, "R5 data col 1");
        send(3'd0, {7'd80, 9'd0, 4'd15, 4'd0}, 1'b1, "R5 data col 80");
        wait_drain();

        // frame B: address then value, periodic stall (R7 R8 R11)
        ready_mode = 1;
        send(3'd2, 24'h00_DABC, 1'b0, "R7 address shift register");
        send(3'd3, 24'h00_BEEF, 1'b1, "R8 value after address");
        wait_drain();

        // frame C: lone service record, irregular stall
        ready_mode = 2;
        send(3'd4, 24'h00_0BAD, 1'b1, "R8 service word");
        send(3'd3, 24'h00_1234, 1'b1, "R8 lone value record");
        send(3'd2, 24'h00_7FFF, 1'b1, "R7 address global register");
        send(3'd7, 24'h00_55AA, 1'b1, "R8 unknown kind as service");
        wait_drain();

        // frame D: gap inside frame (R10)
        ready_mode = 0;
        send(3'd1, 24'h000_F01, 1'b0, "R10 header before gap");
        repeat (20) @(negedge clk);
        send(3'd0, {7'd40, 9'd511, 4'd1, 4'd2}, 1'b1, "R10 data after gap");
        wait_drain();

        // back-to-back frames under random stall
        ready_mode = 2;
        for (int i = 0; i < 24; i++) begin
            automatic logic [2:0] k = 3'(i % 5);
            automatic logic [23:0] f = {lfsr, lfsr[7:0]};
            if (k == 3'd0) f[23:17] = 7'(1 + (i * 7) % 80);
            send(k, f, (i % 4) == 3, "R4 stream record");
        end
        wait_drain();

        check(exp_word.size() == 0, "R11 all records delivered", exp_word.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule